// File: doc/BRIEF.md
# Receive FIFO with trigger and timeout

This block is the receive queue of a serial port. Bytes delivered by the line receiver are stored in a 16-entry circular buffer. Software reads them back one at a time with a pop strobe. A data-ready flag tells software that enough bytes are waiting. It rises when an accepted byte brings the fill level up to a programmable trigger threshold, and it falls when a pop takes the level back below it. A receive interrupt follows the rising of the flag when interrupts are enabled.

A small number of bytes could otherwise wait in the queue with no notice. To prevent that, an idle timer is started whenever a byte is accepted while the level stays under the threshold. The timer counts character-time ticks from the baud generator. After fifteen of them it forces the flag up. A byte that reaches the threshold cancels the timer, and so does a queue clear.

Two small state machines carry the control. The idle timer has the states TMR_IDLE and TMR_RUN. Its transitions are: arm (IDLE or RUN to RUN, reloading 15), expire (RUN to IDLE on the fifteenth tick), and cancel (any state to IDLE, on a clear or on a byte that reaches the threshold). The ready flag has the states FLAG_BELOW and FLAG_READY. Its transitions are: raise (BELOW to READY, on a threshold push or a timer expiry), drop (READY to BELOW, on a pop that leaves the level under the threshold), and flush (any state to BELOW, on a clear).

Top module: `rxq_trig_fifo`

## Requirements
- R1: After reset, level is 0, data_ready is 0, rx_irq is 0 and rd_data is 0.
- R2: The queue holds up to 16 bytes and returns them in arrival order, across pointer wrap. A byte offered while the level is 16 is discarded, and the level stays 16.
- R3: The thresholds selected by trig_sel are 1, 4, 8 and 14, for the values 0, 1, 2 and 3. data_ready rises at the clock edge where an accepted byte makes the level equal to or greater than the threshold.
- R4: rx_irq rises together with data_ready only when rxint_en is 1. It is 0 in the cycle after any cycle with rxint_en at 0, and it never stays 1 while data_ready is 0.
- R5: A pop while the level is nonzero removes the oldest byte and lowers the level by one. rd_data always shows the oldest stored byte. data_ready falls when the resulting level is below the threshold.
- R6: A pop while the level is 0 changes nothing, and rd_data reads 0 while empty. An accepted byte and a pop in the same cycle leave the level unchanged.
- R7: While rx_en is 0, offered bytes are ignored and the level does not change.
- R8: fifo_clr empties the queue, clears data_ready and rx_irq, and cancels a running idle timer. It takes priority over a push or a pop in the same cycle.
- R9: An accepted byte that leaves the level under the threshold (re)starts the idle timer. On the 15th etu_tick after that, data_ready rises, and rx_irq rises too if rxint_en is 1.
- R10: An accepted byte that reaches the threshold cancels a running idle timer, so later ticks cannot raise the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| pop | input | 1 | One-cycle strobe: remove the oldest byte |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| fifo_clr | input | 1 | Synchronous queue clear |
| rx_en | input | 1 | Receiver enable; bytes are accepted only while high |
| rxint_en | input | 1 | Receive interrupt enable |
| etu_tick | input | 1 | One-cycle pulse per character time unit |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| level | output | 5 | Number of stored bytes, 0 to 16 |
| data_ready | output | 1 | Threshold reached or idle timeout seen |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench pushes seventeen bytes into a queue whose pointers have already moved. A design that wrapped wrongly or accepted the extra byte would return bytes out of order or report a level past 16. It counts exactly fourteen and then fifteen ticks after a push, and checks the restart when a second byte arrives partway through. An off-by-one timer would raise the flag a tick early or late, and a timer that is not reloaded would raise it early. It also drives ticks after a threshold push followed by a pop, and after a clear. A design that forgets to cancel the timer would then raise data_ready with bytes sitting below the threshold, or with the queue empty. Pops on an empty queue and a push paired with a pop catch designs that underflow the level or miscount simultaneous strobes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    typedef enum logic {
        FLAG_BELOW = 1'b0,
        FLAG_READY = 1'b1
    } flag_state_t;

    // threshold chosen by the 2-bit select
    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    head;
    logic [AW-1:0]    tail;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[head] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (wr) head <= bump(head);
            if (rd) tail <= bump(tail);
            count <= count + CW'(wr) - CW'(rd);
        end
    end

    assign rdata = (count != '0) ? mem[tail] : '0;

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int UNITS = 15,
    localparam int TW = $clog2(UNITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cancel,
    input  logic tick,
    output logic expire
);
    import rxq_pkg::*;

    tmr_state_t    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: cancel beats arm, arm beats a tick
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cancel) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else if (load) begin
            state_d = TMR_RUN;
            cnt_d   = TW'(UNITS);
        end else begin
            unique case (state_q)
                TMR_IDLE: ;
                TMR_RUN: begin
                    if (tick) begin
                        if (cnt_q == TW'(1)) begin
                            state_d = TMR_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - TW'(1);
                        end
                    end
                end
                default: state_d = TMR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            TMR_IDLE: expire = 1'b0;
            TMR_RUN:  expire = tick && (cnt_q == TW'(1)) && !cancel && !load;
            default:  expire = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxq_trig_fifo.sv
module rxq_trig_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int IDLE_UNITS = 15,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_byte,
    input  logic             pop,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_clr,
    input  logic             rx_en,
    input  logic             rxint_en,
    input  logic             etu_tick,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    level,
    output logic             data_ready,
    output logic             rx_irq
);
    import rxq_pkg::*;

    logic [CW-1:0] trig;
    logic [CW-1:0] next_level;
    logic          push_ok, pop_ok;
    logic          reach, fall, arm, expire, set_evt;
    flag_state_t   flag_q, flag_d;
    logic          irq_q, irq_d;

    assign trig       = CW'(trig_level(trig_sel));
    assign push_ok    = rx_valid && rx_en && (level != CW'(DEPTH)) && !fifo_clr;
    assign pop_ok     = pop && (level != '0) && !fifo_clr;
    assign next_level = level + CW'(push_ok) - CW'(pop_ok);
    assign reach      = push_ok && (next_level >= trig);
    assign arm        = push_ok && (next_level < trig);
    assign fall       = pop_ok && (next_level < trig);
    assign set_evt    = reach || expire;

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .wr    (push_ok),
        .wdata (rx_byte),
        .rd    (pop_ok),
        .rdata (rd_data),
        .count (level)
    );

    rxq_idle_timer #(.UNITS(IDLE_UNITS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (arm),
        .cancel (fifo_clr || reach),
        .tick   (etu_tick),
        .expire (expire)
    );

    // state register for the ready flag and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= FLAG_BELOW;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= irq_d;
        end
    end

    // flag transitions: flush, raise, drop
    always_comb begin
        flag_d = flag_q;
        if (fifo_clr) begin
            flag_d = FLAG_BELOW;
        end else begin
            unique case (flag_q)
                FLAG_BELOW: if (set_evt) flag_d = FLAG_READY;
                FLAG_READY: if (fall && !set_evt) flag_d = FLAG_BELOW;
                default:    flag_d = FLAG_BELOW;
            endcase
        end
    end

    // interrupt follows raise events, falls with the flag or the enable
    always_comb begin
        irq_d = irq_q;
        if (fifo_clr || !rxint_en) begin
            irq_d = 1'b0;
        end else if (set_evt) begin
            irq_d = 1'b1;
        end else if (fall) begin
            irq_d = 1'b0;
        end
    end

    assign data_ready = (flag_q == FLAG_READY);
    assign rx_irq     = irq_q;

endmodule

// File: rtl/rxq_trig_fifo_chk.sv
module rxq_trig_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             pop,
    input logic             fifo_clr,
    input logic             rx_en,
    input logic             rxint_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [CW-1:0]    level,
    input logic             data_ready,
    input logic             rx_irq
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> data_ready);

    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rxint_en |=> !rx_irq);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0 && !rx_valid) |=> (level == '0 && rd_data == '0));

    assert_rx_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !pop && !fifo_clr) |=> $stable(level));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (level == '0 && !data_ready && !rx_irq));

endmodule

bind rxq_trig_fifo rxq_trig_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .pop        (pop),
    .fifo_clr   (fifo_clr),
    .rx_en      (rx_en),
    .rxint_en   (rxint_en),
    .rd_data    (rd_data),
    .level      (level),
    .data_ready (data_ready),
    .rx_irq     (rx_irq)
);

// File: tb/tb_rxq_trig_fifo.sv
`timescale 1ns/1ps
module tb_rxq_trig_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       pop = 1'b0;
    logic [1:0] trig_sel = 2'd1;
    logic       fifo_clr = 1'b0;
    logic       rx_en = 1'b1;
    logic       rxint_en = 1'b1;
    logic       etu_tick = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_ready;
    logic       rx_irq;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rxq_trig_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .pop(pop), .trig_sel(trig_sel), .fifo_clr(fifo_clr), .rx_en(rx_en),
        .rxint_en(rxint_en), .etu_tick(etu_tick), .rd_data(rd_data),
        .level(level), .data_ready(data_ready), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic pop1();
        pop = 1'b1;
        cyc();
        pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            etu_tick = 1'b1;
            cyc();
            etu_tick = 1'b0;
            cyc();
        end
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        cyc();
        fifo_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "level", level, 0);
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "rx_irq", rx_irq, 0);
        chk("R1", "rd_data", rd_data, 0);
    endtask

    task automatic t_threshold();
        trig_sel = 2'd1;
        push(8'h11); push(8'h22); push(8'h33);
        chk("R3", "level below", level, 3);
        chk("R3", "ready below", data_ready, 0);
        push(8'h44);
        chk("R3", "ready at 4", data_ready, 1);
        chk("R4", "irq at 4", rx_irq, 1);
        chk("R5", "oldest", rd_data, 8'h11);
        pop1();
        chk("R5", "next", rd_data, 8'h22);
        chk("R5", "level after pop", level, 3);
        chk("R5", "ready falls", data_ready, 0);
        chk("R4", "irq falls", rx_irq, 0);
        pop1(); pop1(); pop1();
        chk("R5", "drained", level, 0);
        ticks(20);
        chk("R10", "timer cancelled", data_ready, 0);
        trig_sel = 2'd0;
        push(8'hA5);
        chk("R3", "ready at 1", data_ready, 1);
        chk("R5", "single byte", rd_data, 8'hA5);
        pop1();
        chk("R5", "ready off at 0", data_ready, 0);
    endtask

    task automatic t_full();
        trig_sel = 2'd3;
        for (int i = 0; i < 17; i++) push(8'(i * 3 + 1));
        chk("R2", "level full", level, 16);
        chk("R3", "ready at 14+", data_ready, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2", "order", rd_data, i * 3 + 1);
            pop1();
        end
        chk("R2", "empty after drain", level, 0);
        chk("R5", "ready after drain", data_ready, 0);
        trig_sel = 2'd1;
    endtask

    task automatic t_empty_and_pair();
        pop1();
        chk("R6", "empty pop level", level, 0);
        chk("R6", "empty rd_data", rd_data, 0);
        push(8'h07);
        rx_valid = 1'b1; rx_byte = 8'h08; pop = 1'b1;
        cyc();
        rx_valid = 1'b0; pop = 1'b0;
        chk("R6", "pair level", level, 1);
        chk("R6", "pair rd_data", rd_data, 8'h08);
        clear();
        chk("R8", "cleared", level, 0);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        push(8'h99);
        chk("R7", "ignored level", level, 0);
        chk("R7", "ignored rd_data", rd_data, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_timeout();
        trig_sel = 2'd1;
        push(8'h5A);
        ticks(14);
        chk("R9", "14 ticks", data_ready, 0);
        ticks(1);
        chk("R9", "15 ticks", data_ready, 1);
        chk("R9", "irq on expiry", rx_irq, 1);
        clear();
        chk("R8", "clr flag", data_ready, 0);
        chk("R8", "clr irq", rx_irq, 0);
        push(8'h01);
        ticks(10);
        push(8'h02);
        ticks(14);
        chk("R9", "restart 14", data_ready, 0);
        ticks(1);
        chk("R9", "restart 15", data_ready, 1);
        clear();
    endtask

    task automatic t_clear_cancel();
        push(8'h3C);
        clear();
        ticks(20);
        chk("R8", "timer cancelled", data_ready, 0);
        rx_valid = 1'b1; rx_byte = 8'h77; fifo_clr = 1'b1;
        cyc();
        rx_valid = 1'b0; fifo_clr = 1'b0;
        chk("R8", "clear beats push", level, 0);
    endtask

    task automatic t_irq_enable();
        rxint_en = 1'b0;
        for (int i = 0; i < 4; i++) push(8'(i));
        chk("R4", "flag without irq", data_ready, 1);
        chk("R4", "irq masked", rx_irq, 0);
        clear();
        rxint_en = 1'b1;
        for (int i = 0; i < 4; i++) push(8'(i));
        chk("R4", "irq enabled", rx_irq, 1);
        rxint_en = 1'b0;
        cyc();
        chk("R4", "irq disable", rx_irq, 0);
        chk("R4", "flag kept", data_ready, 1);
        rxint_en = 1'b1;
        clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_threshold();
        t_full();
        t_empty_and_pair();
        t_disabled();
        t_timeout();
        t_clear_cancel();
        t_irq_enable();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule